// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous Memory

A single-port synchronous memory that takes the address and every control on the rising clock edge. The data for a write arrives on the edge after that write's address. The memory does not put write data into the storage array straight away. It parks the write in a one-entry buffer, together with the address and the byte enables latched beside it. That parked write moves into the array only when the next write cycle is accepted. Any number of reads may come in between. A read whose address equals the parked address takes each lane the parked write covers from the buffer, and takes the remaining lanes from the array.

The data word has four 9-bit lanes. Lane i occupies bits [9i+8:9i]. Read data is registered and shows at the outputs one cycle after the read address is taken. The outputs use an enable flag, `q_drv`, which a pad ring turns into a three-state driver. A low flag is the high-impedance state. The enable drops after any deselected or write cycle. It is also forced low at once by the output-disable input or by the power-down input. Power-down stops all new cycles and keeps the stored contents.

Top module: `late_write_sram`

## Requirements
- R1: The address, `sel_n`, `wr_n` and `bwe_n` are taken on the rising edge. The write data `d` is taken on the rising edge one cycle after its write's address.
- R2: An accepted write is committed to the array only on the next accepted write edge. Reads in between see the array without it, except through the bypass of R3.
- R3: A read whose address equals the parked write address returns each lane enabled in that write from the parked data. This holds even on the edge where that data is still arriving on `d`. The other lanes come from the array.
- R4: `bwe_n[i]` is active low and selects lane i, bits [9i+8:9i]. A write with `bwe_n` = 4'b1111 changes no byte.
- R5: A read cycle (`sel_n`=0, `wr_n`=1, `pdn`=0 at the edge) puts the read word on `q`, with `q_drv`=1, after that edge.
- R6: Back-to-back reads of the same address leave `q` unchanged.
- R7: After an edge with `sel_n`=1, or after an edge that takes a write, `q_drv` is 0.
- R8: While `pdn`=1, `q_drv` is 0 immediately and no edge starts a read or a write. Array and buffer contents are kept. The data phase of a write already accepted still completes.
- R9: While `oe_n`=1, `q_drv` is 0 immediately, whatever the cycle type. Releasing it restores the held read word without a clock edge.
- R10: Reset (`rst_n`=0) clears the parked-write valid flag and `q_drv`. A read after reset never matches a write parked before reset.
- R11: Each write merges its late data with its own byte enables, even when a later write has already changed `bwe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low cycle select |
| wr_n | input | 1 | Active-low global write enable |
| bwe_n | input | LANES | Active-low per-lane write enables |
| d | input | LANES*LANE_W | Write data, one cycle after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| pdn | input | 1 | Active-high power-down |
| q | output | LANES*LANE_W | Registered read data |
| q_drv | output | 1 | Output drive enable (0 = high impedance) |

## Verification
The bench reads back an address on the edge where its late data is still on `d`. A design that merges only from the buffer register would return stale lanes there. It checks partial-lane writes against older array bytes. A whole-word bypass would overwrite unwritten lanes, and mixing up enable polarity or lane order would scramble the merge. It issues a write with no lanes enabled and a read after reset of an address that was parked before reset. A design that writes on every enable pattern, or that keeps a stale valid flag, would return the wrong word. Power-down and output-disable are changed between edges. A design that gates them only on the clock would still show `q_drv` high at the next sample.

// File: rtl/lw_pkg.sv
// Shared types for the late-write memory.
// Assumes nothing beyond the standard; holds only the cycle-kind encoding.
package lw_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/lw_decode.sv
// Cycle decoder: classifies the controls taken at a rising edge.
// Assumes inputs are stable around the edge; power-down overrides select.
module lw_decode
    import lw_pkg::*;
(
    input  logic sel_n,
    input  logic wr_n,
    input  logic pdn,
    output cyc_e cyc
);
    // Purpose: map select, write enable and power-down to a cycle kind.
    always_comb begin
        if (pdn || sel_n) cyc = CYC_IDLE;
        else if (!wr_n)   cyc = CYC_WRITE;
        else              cyc = CYC_READ;
    end
endmodule

// File: rtl/lw_array.sv
// Storage array split into byte lanes, one memory per lane.
// Assumes at most one lane-masked write per edge; reads are combinational.
module lw_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Purpose: write this lane when the commit selects it.
        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/lw_wbuf.sv
// One-entry late-write buffer with per-lane read bypass.
// Assumes data arrives the edge after its write; the parked write is
// committed on the next accepted write, using its own latched lane enables.
module lw_wbuf
    import lw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cyc_e                    cyc,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        bwe_n,
    input  logic [LANES*LANE_W-1:0] d,
    input  logic [LANES*LANE_W-1:0] arr_data,
    output logic                    cm_en,
    output logic [ADDR_W-1:0]       cm_addr,
    output logic [LANES-1:0]        cm_lane,
    output logic [LANES*LANE_W-1:0] cm_data,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DATA_W = LANES * LANE_W;

    logic              pend_vld;
    logic              data_due;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_lane;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] cur_data;
    logic              hit;

    // Purpose: park address and lane enables of each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_lane <= '0;
        end else if (cyc == CYC_WRITE) begin
            pend_vld  <= 1'b1;
            pend_addr <= addr;
            pend_lane <= ~bwe_n;
        end
    end

    // Purpose: take the late data one edge after its write address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_due  <= 1'b0;
            pend_data <= '0;
        end else begin
            data_due <= (cyc == CYC_WRITE);
            if (data_due) pend_data <= d;
        end
    end

    // Purpose: newest parked data, including data still on the bus.
    assign cur_data = data_due ? d : pend_data;

    assign cm_en   = (cyc == CYC_WRITE) && pend_vld;
    assign cm_addr = pend_addr;
    assign cm_lane = pend_lane;
    assign cm_data = cur_data;

    assign hit = pend_vld && (addr == pend_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign rd_word[g*LANE_W +: LANE_W] = (hit && pend_lane[g])
                                           ? cur_data[g*LANE_W +: LANE_W]
                                           : arr_data[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/late_write_sram.sv
// Late-write pipelined synchronous memory, top level.
// Assumes a single clock domain; oe_n and pdn gate the drive enable
// combinationally, everything else is registered on the rising edge.
module late_write_sram
    import lw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        bwe_n,
    input  logic [LANES*LANE_W-1:0] d,
    input  logic                    oe_n,
    input  logic                    pdn,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_drv
);
    localparam int DATA_W = LANES * LANE_W;

    cyc_e              cyc;
    logic              cm_en;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_lane;
    logic [DATA_W-1:0] cm_data;
    logic [DATA_W-1:0] arr_data;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] q_reg;
    logic              rd_drv;

    lw_decode u_dec (
        .sel_n (sel_n),
        .wr_n  (wr_n),
        .pdn   (pdn),
        .cyc   (cyc)
    );

    lw_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc),
        .addr     (addr),
        .bwe_n    (bwe_n),
        .d        (d),
        .arr_data (arr_data),
        .cm_en    (cm_en),
        .cm_addr  (cm_addr),
        .cm_lane  (cm_lane),
        .cm_data  (cm_data),
        .rd_word  (rd_word)
    );

    lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk     (clk),
        .wr_en   (cm_en),
        .wr_addr (cm_addr),
        .wr_lane (cm_lane),
        .wr_data (cm_data),
        .rd_addr (addr),
        .rd_data (arr_data)
    );

    // Purpose: register read data and the read-cycle drive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_reg  <= '0;
            rd_drv <= 1'b0;
        end else begin
            rd_drv <= (cyc == CYC_READ);
            if (cyc == CYC_READ) q_reg <= rd_word;
        end
    end

    assign q     = q_reg;
    assign q_drv = rd_drv && !oe_n && !pdn;
endmodule

// File: rtl/lw_chk.sv
// Property checker for the late-write memory, bound to the top module.
// Assumes it sees the top's ports and its registered read word.
module lw_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              sel_n,
    input logic              wr_n,
    input logic              oe_n,
    input logic              pdn,
    input logic              q_drv,
    input logic [DATA_W-1:0] q_reg
);
    logic rd_cyc;
    assign rd_cyc = !sel_n && wr_n && !pdn;

    // R7
    wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> !q_drv);
    // R7
    desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !q_drv);
    // R8
    pdn_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |-> !q_drv);
    // R9
    oe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_drv);
    // R5
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cyc |=> (q_drv || oe_n || pdn));
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && $past(rd_cyc) && (addr == $past(addr))) |=> $stable(q_reg));
endmodule

bind late_write_sram lw_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_lw_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .oe_n  (oe_n),
    .pdn   (pdn),
    .q_drv (q_drv),
    .q_reg (q_reg)
);

// File: tb/tb_late_write_sram.sv
// Self-checking bench: vector table, then directed reset, oe and power-down tests.
module tb_late_write_sram;
    localparam int AW = 6;
    localparam int DW = 36;

    localparam logic [DW-1:0] P1 = {9'd1,  9'd2,  9'd3,  9'd4};
    localparam logic [DW-1:0] P2 = {9'd10, 9'd11, 9'd12, 9'd13};
    localparam logic [DW-1:0] QD = {9'd20, 9'd21, 9'd22, 9'd23};
    localparam logic [DW-1:0] M1 = {9'd1,  9'd21, 9'd3,  9'd23};
    localparam logic [DW-1:0] Z4 = {9'd30, 9'd30, 9'd30, 9'd30};
    localparam logic [DW-1:0] L3 = {9'd40, 9'd41, 9'd42, 9'd43};
    localparam logic [DW-1:0] M2 = {9'd40, 9'd21, 9'd3,  9'd23};
    localparam logic [DW-1:0] P5 = {9'd50, 9'd51, 9'd52, 9'd53};
    localparam logic [DW-1:0] P6 = {9'd60, 9'd61, 9'd62, 9'd63};
    localparam logic [DW-1:0] P7 = {9'd70, 9'd71, 9'd72, 9'd73};

    typedef struct packed {
        logic          sel_n;
        logic          wr_n;
        logic [3:0]    bwe_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] din;
        logic          exp_drv;
        logic [DW-1:0] exp_q;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'b0000, 6'd5, '0, 1'b0, '0, 4'd7},  // R7 write at 5
        '{1'b1, 1'b1, 4'b1111, 6'd0, P1, 1'b0, '0, 4'd1},  // R1 late data
        '{1'b0, 1'b1, 4'b1111, 6'd5, '0, 1'b1, P1, 4'd3},  // R3 bypass
        '{1'b0, 1'b1, 4'b1111, 6'd5, '0, 1'b1, P1, 4'd6},  // R6 hold
        '{1'b0, 1'b0, 4'b0000, 6'd9, '0, 1'b0, '0, 4'd2},  // R2 commit 5
        '{1'b0, 1'b0, 4'b1010, 6'd5, P2, 1'b0, '0, 4'd11}, // R11 lanes 0,2
        '{1'b0, 1'b1, 4'b1111, 6'd5, QD, 1'b1, M1, 4'd3},  // R3 merge from bus
        '{1'b0, 1'b1, 4'b1111, 6'd9, '0, 1'b1, P2, 4'd2},  // R2 committed
        '{1'b0, 1'b1, 4'b1111, 6'd5, '0, 1'b1, M1, 4'd3},  // R3 merge from buf
        '{1'b0, 1'b0, 4'b1111, 6'd7, '0, 1'b0, '0, 4'd4},  // R4 no-byte write
        '{1'b0, 1'b1, 4'b1111, 6'd5, Z4, 1'b1, M1, 4'd2},  // R2 array path
        '{1'b0, 1'b0, 4'b0111, 6'd5, '0, 1'b0, '0, 4'd4},  // R4 lane3 only
        '{1'b0, 1'b1, 4'b1111, 6'd5, L3, 1'b1, M2, 4'd4},  // R4 lane3 merge
        '{1'b1, 1'b0, 4'b0000, 6'd5, '0, 1'b0, '0, 4'd7},  // R7 deselect
        '{1'b0, 1'b1, 4'b1111, 6'd9, '0, 1'b1, P2, 4'd5},  // R5 read
        '{1'b0, 1'b0, 4'b0000, 6'd9, '0, 1'b0, '0, 4'd7},  // R7 write hi-z
        '{1'b1, 1'b1, 4'b1111, 6'd0, P5, 1'b0, '0, 4'd1},  // R1 late data
        '{1'b0, 1'b1, 4'b1111, 6'd9, '0, 1'b1, P5, 4'd3},  // R3 bypass
        '{1'b0, 1'b1, 4'b1111, 6'd5, '0, 1'b1, M2, 4'd2}   // R2 committed
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          sel_n, wr_n, oe_n, pdn;
    logic [3:0]    bwe_n;
    logic [DW-1:0] d;
    logic [DW-1:0] q;
    logic          q_drv;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    late_write_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
        .bwe_n(bwe_n), .d(d), .oe_n(oe_n), .pdn(pdn), .q(q), .q_drv(q_drv)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic w, input logic [3:0] be,
                       input logic [AW-1:0] a, input logic [DW-1:0] dd);
        @(negedge clk);
        sel_n = s; wr_n = w; bwe_n = be; addr = a; d = dd;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; bwe_n = 4'hF;
        addr = '0; d = '0; oe_n = 1'b0; pdn = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 drive off in reset", {35'd0, q_drv}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 4'hF, '0, '0);
        chk("R10 drive off after reset", {35'd0, q_drv}, '0);

        // Table walk: row k inputs, outputs sampled after that edge.
        for (int k = 0; k < NV; k++) begin
            cyc(VEC[k].sel_n, VEC[k].wr_n, VEC[k].bwe_n, VEC[k].addr, VEC[k].din);
            checks++;
            if (q_drv !== VEC[k].exp_drv) begin
                errors++;
                $display("FAIL R%0d row %0d q_drv actual=%b expected=%b",
                         VEC[k].req, k, q_drv, VEC[k].exp_drv);
            end
            if (VEC[k].exp_drv) begin
                checks++;
                if (q !== VEC[k].exp_q) begin
                    errors++;
                    $display("FAIL R%0d row %0d q actual=%h expected=%h",
                             VEC[k].req, k, q, VEC[k].exp_q);
                end
            end
        end

        // R10: write to 9 parked before reset must not be bypassed after it.
        @(negedge clk); rst_n = 1'b0; sel_n = 1'b1;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cyc(1'b0, 1'b1, 4'hF, 6'd9, '0);
        chk("R10 read after reset", q, P2);

        // R9: output disable forces hi-z asynchronously, release restores.
        @(negedge clk); oe_n = 1'b1;
        #1;
        chk("R9 oe_n high drive", {35'd0, q_drv}, '0);
        cyc(1'b0, 1'b1, 4'hF, 6'd9, '0);
        chk("R9 oe_n high on read", {35'd0, q_drv}, '0);
        oe_n = 1'b0;
        #0.5;
        chk("R9 oe_n release drive", {35'd0, q_drv}, 36'd1);
        chk("R9 oe_n release data", q, P2);

        // R8: power-down blocks cycles and gates the drive at once.
        @(negedge clk); pdn = 1'b1;
        #1;
        chk("R8 pdn drive", {35'd0, q_drv}, '0);
        cyc(1'b0, 1'b0, 4'h0, 6'd9, '0);
        cyc(1'b0, 1'b1, 4'hF, 6'd9, P6);
        chk("R8 pdn blocks read", {35'd0, q_drv}, '0);
        @(negedge clk); pdn = 1'b0;
        cyc(1'b0, 1'b0, 4'h0, 6'd3, '0);
        cyc(1'b1, 1'b1, 4'hF, '0, P7);
        cyc(1'b0, 1'b1, 4'hF, 6'd9, '0);
        chk("R8 contents kept", q, P2);
        cyc(1'b0, 1'b1, 4'hF, 6'd3, '0);
        chk("R3 bypass after pdn", q, P7);
        cyc(1'b0, 1'b1, 4'hF, 6'd5, '0);
        chk("R2 older commit kept", q, M2);

        finish_run();
    end
endmodule